// File: doc/BRIEF.md
# Multiplexed Bus Master Cycle Sequencer

This block runs single memory read and write cycles as bus master on a shared 16-bit address/data bus that also has 8 separate upper address lines. An internal requester presents a 24-bit address, a write flag, byte enables and write data. The block handshakes the request, walks the bus through its address, turnaround, strobe and hold phases, and returns a one-clock done pulse together with the read data.

Memory paces the access with an active-low ready. The block passes ready through a two-flop synchronizer and waits with the data strobe active for as long as ready stays high. It latches read data on the clock edge where it raises the data strobe. It controls two external transceiver direction enables, and on reads it leaves a gap between turning one off and the other on.

Top module: `mux_bus_master`

## Requirements
- R1: From the clock after a request is accepted through the clock after the address strobe falls, `dal_oe_o` is 1, `dal_o` carries address bits 15:0 and `xcvr_out_o` is 1. `adr_hi_o` carries address bits 23:16 for the whole cycle.
- R2: During a cycle `bm_n_o` equals the bitwise inverse of the byte enables captured at acceptance. Bit 0 selects the low byte and bit 1 the upper byte. Outside a cycle `bm_n_o` is all ones.
- R3: `read_o` is 1 for a read and 0 for a write, and it does not change for the whole cycle.
- R4: `as_o` is high for exactly one clock per cycle. It is preceded by one clock with the address driven and `as_o` low, and followed by one clock in which the address is still driven.
- R5: In a read, `dal_oe_o` and both transceiver enables are low for one turnaround clock. `ds_n_o` falls after that clock, and `dal_oe_o` stays low while `ds_n_o` is low.
- R6: `ds_n_o` rises on the third rising clock edge after `rdy_ni` is first driven low (the synchronizer plus the capture edge). It stays low for as long as `rdy_ni` stays high.
- R7: A read returns on `rdata_o` the value on `dal_i` at the edge where `ds_n_o` rises. The value is valid while `done_o` is high.
- R8: In a write, `dal_o` switches to the write data in the clock after the address hold. `ds_n_o` falls one clock later with the data already driven, and `dal_oe_o` and the data remain for one clock after `ds_n_o` rises.
- R9: `xcvr_in_o` and `xcvr_out_o` are never high together. In a read, `xcvr_in_o` rises only after a clock in which `xcvr_out_o` was low.
- R10: `done_o` is high for exactly one clock per cycle, in the clock where `ds_n_o` has just risen.
- R11: `req_ready_o` is high only when the block is idle and the synchronized ready is high. A request is accepted on a rising edge where `req_i` and `req_ready_o` are both high, so a new cycle never starts until `rdy_ni` has been high for at least two rising edges.
- R12: While `rst_ni` is low, `as_o`, `dal_oe_o`, both transceiver enables and `done_o` are 0, and `ds_n_o` and `bm_n_o` are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted this clock |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 24 | Byte address of the access |
| req_be_i | input | 2 | Byte enables (bit 0 low byte, bit 1 upper byte) |
| req_wdata_i | input | 16 | Write data |
| done_o | output | 1 | One-clock cycle completion pulse |
| rdata_o | output | 16 | Captured read data |
| dal_o | output | 16 | Shared address/data lines, outbound value |
| dal_i | input | 16 | Shared address/data lines, inbound value |
| dal_oe_o | output | 1 | Output enable for the shared lines |
| adr_hi_o | output | 8 | Upper address lines |
| as_o | output | 1 | Address strobe, active high |
| ds_n_o | output | 1 | Data strobe, active low |
| read_o | output | 1 | Cycle direction, 1 = read |
| bm_n_o | output | 2 | Byte mask, active low |
| xcvr_in_o | output | 1 | Transceiver steers data toward the block |
| xcvr_out_o | output | 1 | Transceiver steers address/data away from the block |
| rdy_ni | input | 1 | Memory ready, active low |

## Verification
After an accepting edge, the setup clock follows one edge later, `as_o` two edges later, the address hold three edges later, the turnaround or write-data clock four edges later, and the falling `ds_n_o` five edges later. `ds_n_o` rises, and `done_o` and `rdata_o` appear, exactly three rising edges after the bench drives `rdy_ni` low. The bench drives inputs and samples outputs on the falling edge. A memory model follows the strobes and checks each phase in the half-cycle where it is due, counting falling edges from its own `rdy_ni` assertion. A scoreboard compares every completed cycle with the expected item queued by the driver.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ASTB,
    ST_AHOLD,
    ST_TURN,
    ST_WDAT,
    ST_STRB,
    ST_HOLD
  } bus_state_e;
endpackage

// File: rtl/mbm_sync.sv
module mbm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= RST_VAL;
        else         chain_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mbm_fsm.sv
module mbm_fsm
  import mbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       write_i,
  input  logic       rdy_n_i,
  output bus_state_e state_o,
  output logic       wr_o,
  output logic       accept_o,
  output logic       capture_o
);
  bus_state_e state_q, state_d;
  logic       wr_q;

  assign accept_o  = (state_q == ST_IDLE) && req_i && rdy_n_i;
  // capture coincides with the strobe rising
  assign capture_o = (state_q == ST_STRB) && !rdy_n_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (accept_o) state_d = ST_SETUP;
      ST_SETUP: state_d = ST_ASTB;
      ST_ASTB:  state_d = ST_AHOLD;
      ST_AHOLD: state_d = wr_q ? ST_WDAT : ST_TURN;
      ST_TURN:  state_d = ST_STRB;
      ST_WDAT:  state_d = ST_STRB;
      ST_STRB:  if (capture_o) state_d = ST_HOLD;
      ST_HOLD:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept_o) wr_q <= write_i;
    end
  end

  assign state_o = state_q;
  assign wr_o    = wr_q;
endmodule

// File: rtl/mbm_datapath.sv
module mbm_datapath #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              capture_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] dal_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BE_W-1:0]   be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      be_o    <= '0;
      wdata_o <= '0;
      rdata_o <= '0;
    end else begin
      if (load_i) begin
        addr_o  <= addr_i;
        be_o    <= be_i;
        wdata_o <= wdata_i;
      end
      if (capture_i) rdata_o <= dal_i;
    end
  end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
  import mbm_pkg::*;
#(
  parameter  int ADDR_W      = 24,
  parameter  int DATA_W      = 16,
  parameter  int SYNC_STAGES = 2,
  localparam int BE_W        = DATA_W / 8,
  localparam int HI_W        = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BE_W-1:0]   req_be_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] dal_o,
  input  logic [DATA_W-1:0] dal_i,
  output logic              dal_oe_o,
  output logic [HI_W-1:0]   adr_hi_o,
  output logic              as_o,
  output logic              ds_n_o,
  output logic              read_o,
  output logic [BE_W-1:0]   bm_n_o,
  output logic              xcvr_in_o,
  output logic              xcvr_out_o,
  input  logic              rdy_ni
);
  bus_state_e        state;
  logic              wr, accept, capture, rdy_n_sync;
  logic [ADDR_W-1:0] addr_q;
  logic [BE_W-1:0]   be_q;
  logic [DATA_W-1:0] wdata_q;
  logic              in_cycle, drive_addr, drive_wdat, strobe_phase;

  mbm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rdy_ni),
    .q_o    (rdy_n_sync)
  );

  mbm_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .write_i   (req_write_i),
    .rdy_n_i   (rdy_n_sync),
    .state_o   (state),
    .wr_o      (wr),
    .accept_o  (accept),
    .capture_o (capture)
  );

  mbm_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BE_W(BE_W)) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .capture_i (capture),
    .addr_i    (req_addr_i),
    .be_i      (req_be_i),
    .wdata_i   (req_wdata_i),
    .dal_i     (dal_i),
    .addr_o    (addr_q),
    .be_o      (be_q),
    .wdata_o   (wdata_q),
    .rdata_o   (rdata_o)
  );

  assign in_cycle     = (state != ST_IDLE);
  assign drive_addr   = (state == ST_SETUP) || (state == ST_ASTB) || (state == ST_AHOLD);
  assign strobe_phase = (state == ST_STRB) || (state == ST_HOLD);
  assign drive_wdat   = wr && ((state == ST_WDAT) || strobe_phase);

  assign req_ready_o = (state == ST_IDLE) && rdy_n_sync;
  assign done_o      = (state == ST_HOLD);
  assign dal_oe_o    = drive_addr || drive_wdat;
  assign dal_o       = drive_addr ? addr_q[DATA_W-1:0] : wdata_q;
  assign adr_hi_o    = in_cycle ? addr_q[ADDR_W-1:DATA_W] : '0;
  assign as_o        = (state == ST_ASTB);
  assign ds_n_o      = (state != ST_STRB);
  assign read_o      = in_cycle ? !wr : 1'b1;
  assign bm_n_o      = in_cycle ? ~be_q : '1;
  assign xcvr_out_o  = dal_oe_o;
  // turnaround state leaves both enables low before inbound turns on
  assign xcvr_in_o   = !wr && strobe_phase;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
  parameter int BE_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            as_o,
  input logic            ds_n_o,
  input logic            read_o,
  input logic            dal_oe_o,
  input logic            xcvr_in_o,
  input logic            xcvr_out_o,
  input logic            done_o,
  input logic [BE_W-1:0] bm_n_o,
  input logic            req_ready_o
);
  p_xcvr_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(xcvr_in_o && xcvr_out_o));

  p_xcvr_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xcvr_in_o) |-> !$past(xcvr_out_o));

  p_as_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    as_o |=> !as_o);

  p_as_setup_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(as_o) |-> $past(dal_oe_o));

  p_rd_float_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ds_n_o && read_o) |-> !dal_oe_o);

  p_wr_drive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ds_n_o && !read_o) |-> dal_oe_o);

  p_wr_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ds_n_o) && !read_o) |-> dal_oe_o);

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_ds_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ds_n_o) |-> done_o);

  p_dir_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bm_n_o != '1 && $past(bm_n_o) != '1) |-> $stable(read_o));

  p_ready_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (bm_n_o == '1 && ds_n_o && !as_o));
endmodule

bind mux_bus_master mbm_checker #(.BE_W(BE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .as_o        (as_o),
  .ds_n_o      (ds_n_o),
  .read_o      (read_o),
  .dal_oe_o    (dal_oe_o),
  .xcvr_in_o   (xcvr_in_o),
  .xcvr_out_o  (xcvr_out_o),
  .done_o      (done_o),
  .bm_n_o      (bm_n_o),
  .req_ready_o (req_ready_o)
);

// File: tb/mux_bus_master_bench.sv
`timescale 1ns/1ps
module mux_bus_master_bench;
  typedef struct {
    logic        wr;
    logic [23:0] addr;
    logic [1:0]  be;
    logic [15:0] data;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0;
  logic [23:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic [15:0] dal_i = 16'hDEAD;
  logic        rdy_ni = 1'b1;
  logic        req_ready_o, done_o, dal_oe_o, as_o, ds_n_o, read_o, xcvr_in_o, xcvr_out_o;
  logic [15:0] rdata_o, dal_o;
  logic [7:0]  adr_hi_o;
  logic [1:0]  bm_n_o;

  int n_chk = 0, n_fail = 0, n_done = 0;
  item_t exp_q[$];
  int cfg_wait = 0, cfg_stick = 0;

  always #2.5 clk_i = ~clk_i;

  mux_bus_master u_mux_bus_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .req_ready_o(req_ready_o),
    .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_be_i(req_be_i),
    .req_wdata_i(req_wdata_i), .done_o(done_o), .rdata_o(rdata_o), .dal_o(dal_o),
    .dal_i(dal_i), .dal_oe_o(dal_oe_o), .adr_hi_o(adr_hi_o), .as_o(as_o),
    .ds_n_o(ds_n_o), .read_o(read_o), .bm_n_o(bm_n_o), .xcvr_in_o(xcvr_in_o),
    .xcvr_out_o(xcvr_out_o), .rdy_ni(rdy_ni)
  );

  function automatic logic [15:0] mem_fn(logic [23:0] a);
    return a[15:0] ^ 16'hA5C3 ^ {a[23:16], 8'h00};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model + monitor, one process so observation precedes driving
  logic        p_as = 0, p_ds_n = 1, p_in = 0, p_out = 0, p_oe = 0, p_done = 0;
  logic [15:0] p_dal = '0;
  logic [1:0]  p_bm = 2'b11;
  logic [23:0] ob_addr = '0;
  logic [15:0] ob_wdata = '0;
  int rdy_hi_cnt = 0, as_cnt = 0, wcnt = 0, rdy_age = 0, stick_cnt = 0;
  bit rdy_on = 0, stick_on = 0;

  always @(negedge clk_i) begin
    if (rst_ni) begin
      item_t e;
      rdy_hi_cnt = rdy_ni ? rdy_hi_cnt + 1 : 0;
      if (rdy_on) rdy_age++;
      e = (exp_q.size() > 0) ? exp_q[0] : '{1'b0, 24'h0, 2'b00, 16'h0};

      if (xcvr_in_o && xcvr_out_o) chk(0, "R9", "both enables", 2'b11, 2'b00);
      if (xcvr_in_o && !p_in) chk(!p_out, "R9", "gap before inbound", p_out, 0);

      if (p_bm == 2'b11 && bm_n_o != 2'b11) begin
        chk(exp_q.size() > 0, "R11", "cycle without request", 0, 1);
        chk(rdy_hi_cnt >= 3, "R11", "ready high samples before start", rdy_hi_cnt, 3);
        chk(dal_oe_o && !as_o && dal_o == e.addr[15:0], "R1", "setup address",
            dal_o, e.addr[15:0]);
        chk(xcvr_out_o, "R1", "outbound in setup", xcvr_out_o, 1);
        chk(adr_hi_o == e.addr[23:16], "R1", "upper address", adr_hi_o, e.addr[23:16]);
        chk(bm_n_o == ~e.be, "R2", "byte mask", bm_n_o, ~e.be);
        chk(read_o == !e.wr, "R3", "direction", read_o, !e.wr);
        as_cnt = 0;
      end
      if (as_o) begin
        ob_addr = {adr_hi_o, dal_o};
        as_cnt++;
        if (p_as) chk(0, "R4", "strobe longer than one clock", 2, 1);
      end
      if (p_as && !as_o)
        chk(dal_oe_o && dal_o == ob_addr[15:0], "R4", "address hold after strobe",
            dal_o, ob_addr[15:0]);
      if (bm_n_o != 2'b11 && p_bm != 2'b11) begin
        if (bm_n_o != p_bm) chk(0, "R2", "mask changed in cycle", bm_n_o, p_bm);
        if (adr_hi_o != ob_addr[23:16] && as_cnt > 0)
          chk(0, "R1", "upper address changed", adr_hi_o, ob_addr[23:16]);
      end

      if (!ds_n_o && p_ds_n) begin
        if (read_o) begin
          chk(!dal_oe_o && !xcvr_out_o, "R5", "float during strobe", dal_oe_o, 0);
          chk(!p_oe && !p_out && !p_in && !p_as, "R5", "turnaround clock", p_oe, 0);
        end else begin
          chk(dal_oe_o && dal_o == e.data, "R8", "write data at strobe", dal_o, e.data);
          chk(p_oe && p_dal == e.data && !p_as, "R8", "data before strobe", p_dal, e.data);
          ob_wdata = dal_o;
        end
        wcnt = 0;
      end
      if (!ds_n_o && read_o && dal_oe_o) chk(0, "R5", "driving during read strobe", 1, 0);

      if (ds_n_o && !p_ds_n) begin
        chk(rdy_on && rdy_age == 3, "R6", "strobe rise latency", rdy_age, 3);
        chk(done_o, "R10", "done with strobe rise", done_o, 1);
        if (!read_o)
          chk(dal_oe_o && dal_o == ob_wdata, "R8", "write data hold", dal_o, ob_wdata);
        rdy_on = 0;
        dal_i = 16'hDEAD;
        stick_cnt = cfg_stick;
        stick_on = 1;
      end

      if (done_o) begin
        if (p_done) chk(0, "R10", "done longer than one clock", 2, 1);
        if (exp_q.size() == 0) chk(0, "R10", "done without request", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(ob_addr == e.addr, "R1", "latched address", ob_addr, e.addr);
          chk(as_cnt == 1, "R4", "strobes per cycle", as_cnt, 1);
          chk(read_o == !e.wr, "R3", "direction at end", read_o, !e.wr);
          if (e.wr) chk(ob_wdata == e.data, "R8", "scoreboard write", ob_wdata, e.data);
          else chk(rdata_o == e.data, "R7", "scoreboard read", rdata_o, e.data);
        end
        n_done++;
      end

      // drive stage
      if (!ds_n_o && !rdy_on) begin
        if (wcnt >= cfg_wait) begin
          rdy_ni = 1'b0;
          dal_i = mem_fn(ob_addr);
          rdy_on = 1;
          rdy_age = 0;
        end else wcnt++;
      end
      if (stick_on) begin
        if (stick_cnt == 0) begin
          rdy_ni = 1'b1;
          stick_on = 0;
        end else stick_cnt--;
      end

      p_as = as_o; p_ds_n = ds_n_o; p_in = xcvr_in_o; p_out = xcvr_out_o;
      p_oe = dal_oe_o; p_dal = dal_o; p_bm = bm_n_o; p_done = done_o;
    end
  end

  task automatic run(logic wr, logic [23:0] a, logic [1:0] be, logic [15:0] wd,
                     int wt, int st);
    item_t it;
    int target;
    it.wr = wr; it.addr = a; it.be = be; it.data = wr ? wd : mem_fn(a);
    target = n_done + 1;
    @(negedge clk_i);
    cfg_wait = wt; cfg_stick = st;
    exp_q.push_back(it);
    req_i = 1'b1; req_write_i = wr; req_addr_i = a; req_be_i = be; req_wdata_i = wd;
    while (!req_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0; req_wdata_i = ~wd;
    while (n_done < target) @(negedge clk_i);
  endtask

  bit finished = 0;
  initial begin
    repeat (3) @(negedge clk_i);
    // R12 reset state
    chk(!as_o && !dal_oe_o && !xcvr_in_o && !xcvr_out_o && !done_o, "R12",
        "reset outputs low", {as_o, dal_oe_o, xcvr_in_o, xcvr_out_o, done_o}, 0);
    chk(ds_n_o && bm_n_o == 2'b11, "R12", "reset outputs high", {ds_n_o, bm_n_o}, 3'b111);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(req_ready_o, "R11", "ready when idle", req_ready_o, 1);
    run(1'b0, 24'h12_3456, 2'b11, 16'h0000, 0, 0);
    run(1'b1, 24'hAB_CDEF, 2'b11, 16'hBEEF, 0, 0);
    run(1'b0, 24'h00_0001, 2'b10, 16'h0000, 3, 0);
    run(1'b1, 24'h7F_0002, 2'b01, 16'h1234, 5, 0);
    run(1'b0, 24'hFF_FFFE, 2'b11, 16'h0000, 1, 4);
    // R11 ready held low after a cycle: no new cycle may start
    @(negedge clk_i); rdy_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(!req_ready_o, "R11", "not ready while memory ready low", req_ready_o, 0);
    rdy_ni = 1'b1;
    run(1'b1, 24'h00_0000, 2'b11, 16'hFFFF, 20, 2);
    run(1'b0, 24'h5A_A55A, 2'b01, 16'h0000, 0, 1);
    run(1'b1, 24'hC3_3C00, 2'b10, 16'h8001, 2, 0);
    repeat (5) @(negedge clk_i);
    chk(exp_q.size() == 0, "R10", "all cycles completed", exp_q.size(), 0);
    chk(!done_o && ds_n_o && !dal_oe_o, "R10", "idle after last cycle",
        {done_o, ds_n_o, dal_oe_o}, 3'b010);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      chk(0, "R10", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule